// File: doc/BRIEF.md
# SPI Serial ROM Slave Controller

This block is the device side of a read-only serial memory on an SPI bus. A fast system clock oversamples the bus pins (serial clock, active-low chip select and serial data in). The block finds the serial clock edges from those samples and decodes an 8-bit opcode after chip select falls. It then answers one of three commands: a plain read, a fast read that needs one extra ignored byte before the data, and an identification read that returns a fixed three-byte code.

For the two read commands, a 24-bit address is shifted in most significant bit first. Only the low `ADDR_W` bits are kept. Bytes then stream out of a small internal memory, and the address steps by one after every byte, wrapping to zero past the top. Serial data out comes with an output-enable flag, so the pad can be tri-stated. Any other opcode parks the block silently until chip select falls again.

Top module: `spi_serial_rom`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe_o` is 0. After reset `so_o` is 0.
- R2: Input bits are taken on serial clock rising edges, and `so_o` changes only on falling edges. Both idle-low (mode 0) and idle-high (mode 3) clocks work. With an idle-high clock, the high level already present when chip select falls is not counted as an edge.
- R3: Opcode 03h reads memory. It takes 24 address bits, A23 first, and data bytes go out D7 first. The first data bit appears at the falling edge that follows the last address bit. The memory byte at address a is the low 8 bits of a*37+107.
- R4: Opcode 0Bh behaves like 03h, except that 8 dummy bits follow the address. Their value has no effect on the data.
- R5: Opcode 9Fh returns C2h, 05h, 18h, MSB first, and then 00h for every later byte until chip select rises.
- R6: The address increases by one after each byte sent. It is truncated to `ADDR_W` bits, so address 2^ADDR_W-1 is followed by 0, and address bits above `ADDR_W` are ignored.
- R7: `so_oe_o` stays 0 while the opcode, address and dummy bits are shifted in. It goes to 1 with the first output bit.
- R8: An opcode other than 03h, 0Bh or 9Fh leaves `so_oe_o` at 0 for all further clocks, until chip select falls again. A following command then works normally.
- R9: Raising chip select in the middle of a byte ends the command. `so_oe_o` is 0 within 3 clock cycles, and the next command starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock from the bus master |
| csn_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data from master |
| so_o | output | 1 | Serial data to master |
| so_oe_o | output | 1 | Output enable for `so_o`; 0 means high impedance |

## Verification
Each bus pin passes two synchronizer flops, and the state register adds a third. So `so_o` and `so_oe_o` settle 3 system cycles after a serial clock fall, and `so_oe_o` drops 3 cycles after chip select rises. The bench holds every serial clock half-period for 8 system cycles and acts only on falling system clock edges. It reads `so_o` at the end of each low half, just before it raises the clock. It checks the output enable 4 cycles after raising chip select. Expected bytes come from the memory formula and the address arithmetic modulo 256, over a sweep of start addresses in both clock modes.

// File: rtl/srom_pkg.sv
package srom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_ID,
        ST_STANDBY
    } srom_state_e;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_IDENT = 8'h9F;

    localparam logic [7:0] ID_B0 = 8'hC2;
    localparam logic [7:0] ID_B1 = 8'h05;
    localparam logic [7:0] ID_B2 = 8'h18;

    localparam int ADDR_BITS_BUS = 24;

endpackage

// File: rtl/srom_pin_sync.sv
module srom_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    // Chain of STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0][WIDTH-1:0] chain_q;
    logic [STAGES:0][WIDTH-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/srom_array.sv
module srom_array #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    // Content is a fixed function of the address: low byte of addr*37+107.
    logic [31:0] mix;

    always_comb begin
        mix     = 32'(rd_addr) * 32'd37 + 32'd107;
        rd_data = mix[7:0];
    end

endmodule

// File: rtl/spi_serial_rom.sv
module spi_serial_rom
    import srom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic si_i,
    output logic so_o,
    output logic so_oe_o
);

    localparam int CNT_W      = $clog2(ADDR_BITS_BUS);
    localparam int LAST_ADDR  = ADDR_BITS_BUS - 1;

    typedef struct packed {
        srom_state_e       state;
        logic [CNT_W-1:0]  bcnt;
        logic              fast;
        logic [7:0]        shin;
        logic [7:0]        shout;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        id_idx;
        logic              so;
        logic              oe;
    } srom_regs_t;

    srom_regs_t cur_q, nxt_d;

    // ---------------- pin sampling ----------------
    logic [2:0] pins_s, pins_p;
    logic       cs_s, sclk_s, sclk_p, si_s;
    logic       rise_ev, fall_ev;

    srom_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({csn_i, sclk_i, si_i}),
        .sync_o  (pins_s),
        .prev_o  (pins_p)
    );

    assign cs_s    = pins_s[2];
    assign sclk_s  = pins_s[1];
    assign si_s    = pins_s[0];
    assign sclk_p  = pins_p[1];
    assign rise_ev = sclk_s & ~sclk_p;
    assign fall_ev = ~sclk_s & sclk_p;

    // ---------------- memory read port ----------------
    logic [7:0] mem_rd;

    srom_array #(.ADDR_W(ADDR_W)) u_mem (
        .rd_addr (cur_q.addr),
        .rd_data (mem_rd)
    );

    logic [7:0] id_byte;
    always_comb begin
        case (cur_q.id_idx)
            2'd0:    id_byte = ID_B0;
            2'd1:    id_byte = ID_B1;
            2'd2:    id_byte = ID_B2;
            default: id_byte = 8'h00;
        endcase
    end

    // ---------------- next state ----------------
    logic [7:0] opc;
    logic [7:0] load_byte;

    always_comb begin
        nxt_d     = cur_q;
        opc       = {cur_q.shin[6:0], si_s};
        load_byte = (cur_q.state == ST_DATA) ? mem_rd : id_byte;

        if (cs_s) begin
            nxt_d.state = ST_IDLE;
            nxt_d.bcnt  = '0;
            nxt_d.oe    = 1'b0;
            nxt_d.fast  = 1'b0;
        end else begin
            case (cur_q.state)
                ST_IDLE, ST_CMD: begin
                    nxt_d.state = ST_CMD;
                    if (rise_ev) begin
                        nxt_d.shin = opc;
                        if (cur_q.bcnt == CNT_W'(7)) begin
                            nxt_d.bcnt = '0;
                            case (opc)
                                OP_READ:  begin nxt_d.state = ST_ADDR; nxt_d.fast = 1'b0; end
                                OP_FAST:  begin nxt_d.state = ST_ADDR; nxt_d.fast = 1'b1; end
                                OP_IDENT: begin nxt_d.state = ST_ID;   nxt_d.id_idx = 2'd0; end
                                default:  nxt_d.state = ST_STANDBY;
                            endcase
                        end else begin
                            nxt_d.bcnt = cur_q.bcnt + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise_ev) begin
                        nxt_d.addr = {cur_q.addr[ADDR_W-2:0], si_s};
                        if (cur_q.bcnt == CNT_W'(LAST_ADDR)) begin
                            nxt_d.bcnt  = '0;
                            nxt_d.state = cur_q.fast ? ST_DUMMY : ST_DATA;
                        end else begin
                            nxt_d.bcnt = cur_q.bcnt + 1'b1;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (rise_ev) begin
                        if (cur_q.bcnt == CNT_W'(7)) begin
                            nxt_d.bcnt  = '0;
                            nxt_d.state = ST_DATA;
                        end else begin
                            nxt_d.bcnt = cur_q.bcnt + 1'b1;
                        end
                    end
                end
                ST_DATA, ST_ID: begin
                    if (fall_ev) begin
                        nxt_d.oe = 1'b1;
                        if (cur_q.bcnt == '0) begin
                            nxt_d.so    = load_byte[7];
                            nxt_d.shout = {load_byte[6:0], 1'b0};
                            if (cur_q.state == ST_DATA)
                                nxt_d.addr = cur_q.addr + 1'b1;
                            else if (cur_q.id_idx != 2'd3)
                                nxt_d.id_idx = cur_q.id_idx + 1'b1;
                        end else begin
                            nxt_d.so    = cur_q.shout[7];
                            nxt_d.shout = {cur_q.shout[6:0], 1'b0};
                        end
                        nxt_d.bcnt = (cur_q.bcnt == CNT_W'(7)) ? '0 : cur_q.bcnt + 1'b1;
                    end
                end
                default: ; // standby: wait for chip select to rise
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, bcnt: '0, fast: 1'b0, shin: '0, shout: '0,
                       addr: '0, id_idx: '0, so: 1'b0, oe: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign so_o    = cur_q.so;
    assign so_oe_o = cur_q.oe;

    // ---------------- assertions ----------------
    srom_state_e       st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  bcnt_q;
    assign st_q   = cur_q.state;
    assign addr_q = cur_q.addr;
    assign bcnt_q = cur_q.bcnt;

    // R9 / R1: chip select high drops the output enable on the next cycle
    a_r9_cs_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe_o);

    // R2: serial output moves only on a detected falling edge
    a_r2_so_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(so_o));

    // R7: driving only happens in the output phases
    a_r7_oe_in_output_phase: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe_o |-> (st_q == ST_DATA || st_q == ST_ID));

    // R8: standby never drives the line
    a_r8_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STANDBY) |-> !so_oe_o);

    // R6: each byte load steps the address by one, modulo the memory size
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && fall_ev && !cs_s && bcnt_q == '0)
        |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

endmodule

// File: tb/sim_spi_serial_rom.sv
module sim_spi_serial_rom;

    localparam int H = 8;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic si = 1'b0;
    logic so, so_oe;

    int  checks = 0;
    int  errors = 0;
    bit  mode3  = 1'b0;
    bit  in_oe_hit;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    spi_serial_rom #(.ADDR_W(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .csn_i   (csn),
        .si_i    (si),
        .so_o    (so),
        .so_oe_o (so_oe)
    );

    function automatic logic [7:0] rom_at(input int a);
        int v;
        v = (a % (1 << W)) * 37 + 107;
        return v[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic start(input bit m3);
        mode3 = m3;
        sclk  = m3;
        half();
        csn = 1'b0;
        half();
    endtask

    task automatic stop();
        if (!mode3) begin
            sclk = 1'b0;
            half();
        end
        csn = 1'b1;
        half();
        half();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            si   = b[i];
            half();
            if (so_oe) in_oe_hit = 1'b1;
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit oe_all);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            si   = 1'b0;
            half();
            b[i] = so;
            if (!so_oe) oe_all = 1'b0;
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic do_read(input bit m3, input logic [7:0] op, input logic [23:0] a,
                           input logic [7:0] dmy, input int n, input string req);
        logic [7:0] got;
        logic [7:0] exp;
        bit         oe_ok;
        start(m3);
        in_oe_hit = 1'b0;
        send_byte(op);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        if (op == 8'h0B) send_byte(dmy);
        chk(!in_oe_hit, "R7 oe low during input phase", int'(in_oe_hit), 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(got, oe_ok);
            exp = rom_at(int'(a) + k);
            chk(oe_ok && got == exp, req, int'(got), int'(exp));
        end
        stop();
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        bit         oe_ok;
        logic [7:0] id_exp [5];
        id_exp[0] = 8'hC2; id_exp[1] = 8'h05; id_exp[2] = 8'h18;
        id_exp[3] = 8'h00; id_exp[4] = 8'h00;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(so_oe == 1'b0, "R1 oe after reset", int'(so_oe), 0);
        chk(so == 1'b0, "R1 so after reset", int'(so), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(so_oe == 1'b0, "R1 oe idle with cs high", int'(so_oe), 0);

        // R3 / R2: sweep of start addresses, alternating clock modes
        for (int a = 0; a < 256; a += 15)
            do_read(a[0], 8'h03, 24'(a), 8'h00, 3, "R3 R2 read sweep");

        // R4: fast read with different dummy values
        do_read(1'b0, 8'h0B, 24'h000040, 8'h00, 3, "R4 fast read dummy 00");
        do_read(1'b1, 8'h0B, 24'h000040, 8'hFF, 3, "R4 fast read dummy FF");
        do_read(1'b0, 8'h0B, 24'h0000C7, 8'hA5, 3, "R4 fast read dummy A5");

        // R6: wrap at top address and truncation of upper address bits
        do_read(1'b0, 8'h03, 24'h0000FE, 8'h00, 4, "R6 wrap plain read");
        do_read(1'b1, 8'h0B, 24'h0000FF, 8'h3C, 3, "R6 wrap fast read");
        do_read(1'b0, 8'h03, 24'hAB12FD, 8'h00, 4, "R6 upper bits ignored");

        // R5: identification in both modes
        for (int m = 0; m < 2; m++) begin
            start(m[0]);
            in_oe_hit = 1'b0;
            send_byte(8'h9F);
            chk(!in_oe_hit, "R7 oe low during id opcode", int'(in_oe_hit), 0);
            for (int k = 0; k < 5; k++) begin
                recv_byte(got, oe_ok);
                chk(oe_ok && got == id_exp[k], "R5 id byte", int'(got), int'(id_exp[k]));
            end
            stop();
        end

        // R8: unknown opcode stays silent, then recovery
        for (int m = 0; m < 2; m++) begin
            start(m[0]);
            in_oe_hit = 1'b0;
            send_byte(8'h5A);
            send_byte(8'h03);
            send_byte(8'h00);
            send_byte(8'h10);
            chk(!in_oe_hit, "R8 standby input ignored", int'(in_oe_hit), 0);
            recv_byte(got, oe_ok);
            chk(!in_oe_hit && so_oe == 1'b0, "R8 standby no drive", int'(so_oe), 0);
            stop();
        end
        do_read(1'b0, 8'h03, 24'h000033, 8'h00, 2, "R8 read after standby");

        // R9: abort in the middle of a data byte
        start(1'b0);
        send_byte(8'h03);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h10);
        recv_byte(got, oe_ok);
        chk(oe_ok && got == rom_at(16), "R9 byte before abort", int'(got), int'(rom_at(16)));
        for (int b = 0; b < 3; b++) begin
            sclk = 1'b0; half();
            sclk = 1'b1; half();
        end
        chk(so_oe == 1'b1, "R9 oe driven mid byte", int'(so_oe), 1);
        csn = 1'b1;
        repeat (4) @(negedge clk);
        chk(so_oe == 1'b0, "R9 oe released after cs rise", int'(so_oe), 0);
        sclk = 1'b0;
        half();
        do_read(1'b0, 8'h03, 24'h000020, 8'h00, 2, "R9 read after abort");

        // R9 abort during address phase, mode 3
        start(1'b1);
        send_byte(8'h0B);
        send_byte(8'h00);
        sclk = 1'b0; half();
        sclk = 1'b1; half();
        csn = 1'b1;
        half();
        do_read(1'b1, 8'h0B, 24'h000081, 8'h11, 2, "R9 fast read after address abort");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule